// File: doc/BRIEF.md
# Register File with Hardwired Zero Entry

This block is the integer register store of a small processor core. It holds a bank of 32 words of 32 bits. Two independent read ports, each addressed by a 5-bit index, return the selected word combinationally. One write port stores a word on the rising clock edge when its write enable is high. Entry 0 is not storage at all: it reads as zero and drops any write aimed at it.

The clock reaches every storage flop directly. A write enable never gates the clock. Instead, each entry picks, through a data-path multiplexer, between its own value and the incoming write data. Eight fixed entries (1, 2, 5, 6, 7, 8, 9 and 10) are also brought out on dedicated observation outputs, so a test environment can follow them without using the read ports. No bypass exists: a read in the same cycle as a write to the same entry sees the old word.

Top module: `regfile_z0`

## Requirements
- R1: While `rst_n` is low, every entry is asynchronously cleared to zero. After reset both read ports and all eight observation outputs show zero.
- R2: When `wr_en` is 1 at a rising edge of `clk` and `wr_addr` is not 0, the entry at `wr_addr` takes `wr_data`. The new word appears on any read port addressing that entry from the following cycle on.
- R3: Index 0 always reads as 0x00000000 on both read ports. A write with `wr_addr` = 0 and `wr_en` = 1 leaves index 0 reading zero.
- R4: When `wr_en` is 0 at a clock edge, no entry changes, whatever `wr_addr` and `wr_data` carry.
- R5: A write changes only the addressed entry. Every other entry keeps its word.
- R6: The two read ports are independent and combinational. Each returns the entry selected by its own address in the same cycle, and both may address the same entry.
- R7: A read of the entry being written in the same cycle returns the word it held before the edge.
- R8: The observation outputs `obs_e1`, `obs_e2`, `obs_e5`, `obs_e6`, `obs_e7`, `obs_e8`, `obs_e9` and `obs_e10` always show the words in entries 1, 2, 5, 6, 7, 8, 9 and 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, wired straight to every storage flop |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wr_en | input | 1 | Write enable for the write port |
| wr_addr | input | 5 | Index of the entry to write |
| wr_data | input | 32 | Word to store |
| rd_addr_a | input | 5 | Index for read port A |
| rd_addr_b | input | 5 | Index for read port B |
| rd_data_a | output | 32 | Word at `rd_addr_a` |
| rd_data_b | output | 32 | Word at `rd_addr_b` |
| obs_e1 | output | 32 | Word in entry 1 |
| obs_e2 | output | 32 | Word in entry 2 |
| obs_e5 | output | 32 | Word in entry 5 |
| obs_e6 | output | 32 | Word in entry 6 |
| obs_e7 | output | 32 | Word in entry 7 |
| obs_e8 | output | 32 | Word in entry 8 |
| obs_e9 | output | 32 | Word in entry 9 |
| obs_e10 | output | 32 | Word in entry 10 |

## Verification
The assertions assume that `rst_n` is released away from a clock edge and that the write and read inputs are stable around each rising edge. They also assume the address inputs only carry indices below the bank depth, which always holds for the default 32 entries with 5-bit indices. The bench changes every input half a period away from the rising edge and keeps all addresses within 0 to 31. It applies reset only at a falling edge, so each property sees clean one-cycle histories for write, hold and read-after-write behaviour.

// File: rtl/rf_pkg.sv
package rf_pkg;

  // Number of always-visible observation taps.
  localparam int unsigned TAP_COUNT = 8;

  // Entry index watched by each observation tap, in port order.
  function automatic int unsigned tap_index(input int unsigned slot);
    int unsigned idx;
    case (slot)
      0:       idx = 1;
      1:       idx = 2;
      2:       idx = 5;
      3:       idx = 6;
      4:       idx = 7;
      5:       idx = 8;
      6:       idx = 9;
      default: idx = 10;
    endcase
    return idx;
  endfunction

endpackage

// File: rtl/rf_wr_decode.sv
// Turns the write port into one load strobe per writable entry.
// Strobe bit k drives entry k+1; entry 0 has no strobe at all.
module rf_wr_decode #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [DEPTH-2:0]  load_strobe
);

  always_comb begin
    for (int k = 0; k < int'(DEPTH) - 1; k++) begin
      load_strobe[k] = wr_en && (wr_addr == ADDR_W'(k + 1));
    end
  end

  // R5: at most one entry is loaded per edge.
  p_single_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_strobe));

  // R4: with the port disabled no strobe may fire.
  p_idle_no_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (load_strobe == '0));

endmodule

// File: rtl/rf_entry.sv
// One writable storage word. The clock is never gated: the load
// strobe selects between the held word and the incoming data.
module rf_entry #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] word_r;
  logic [DATA_W-1:0] word_nxt;

  // Next-state: data-path enable instead of a gated clock.
  always_comb begin
    word_nxt = word_r;
    if (load) begin
      word_nxt = d;
    end
  end

  // State register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_r <= '0;
    end else begin
      word_r <= word_nxt;
    end
  end

  assign q = word_r;

  // R2: a loaded word appears one edge later.
  p_load_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(d)));

endmodule

// File: rtl/rf_read_mux.sv
// Combinational read port over the flattened bank.
module rf_read_mux #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic [DEPTH-1:0][DATA_W-1:0] bank,
  input  logic [ADDR_W-1:0]            addr,
  output logic [DATA_W-1:0]            data
);

  always_comb begin
    data = '0;
    for (int k = 0; k < int'(DEPTH); k++) begin
      if (addr == ADDR_W'(k)) begin
        data = bank[k];
      end
    end
  end

endmodule

// File: rtl/regfile_z0.sv
module regfile_z0 #(
  parameter  int unsigned DATA_W = 32,
  parameter  int unsigned DEPTH  = 32,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b,
  output logic [DATA_W-1:0] obs_e1,
  output logic [DATA_W-1:0] obs_e2,
  output logic [DATA_W-1:0] obs_e5,
  output logic [DATA_W-1:0] obs_e6,
  output logic [DATA_W-1:0] obs_e7,
  output logic [DATA_W-1:0] obs_e8,
  output logic [DATA_W-1:0] obs_e9,
  output logic [DATA_W-1:0] obs_e10
);

  logic [DEPTH-2:0]             load_strobe;
  logic [DEPTH-1:0][DATA_W-1:0] bank;
  logic [DATA_W-1:0]            taps [rf_pkg::TAP_COUNT];

  rf_wr_decode #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
  ) u_wr_decode (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .load_strobe (load_strobe)
  );

  // Index 0 is a constant, not storage.
  assign bank[0] = '0;

  generate
    for (genvar g = 1; g < int'(DEPTH); g++) begin : g_entry
      rf_entry #(
        .DATA_W (DATA_W)
      ) u_entry (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_strobe[g-1]),
        .d     (wr_data),
        .q     (bank[g])
      );
    end
  endgenerate

  rf_read_mux #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
  ) u_read_a (
    .bank (bank),
    .addr (rd_addr_a),
    .data (rd_data_a)
  );

  rf_read_mux #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
  ) u_read_b (
    .bank (bank),
    .addr (rd_addr_b),
    .data (rd_data_b)
  );

  generate
    for (genvar t = 0; t < int'(rf_pkg::TAP_COUNT); t++) begin : g_tap
      assign taps[t] = bank[rf_pkg::tap_index(t)];
    end
  endgenerate

  assign obs_e1  = taps[0];
  assign obs_e2  = taps[1];
  assign obs_e5  = taps[2];
  assign obs_e6  = taps[3];
  assign obs_e7  = taps[4];
  assign obs_e8  = taps[5];
  assign obs_e9  = taps[6];
  assign obs_e10 = taps[7];

  // R1: right after reset release port A reads zero.
  p_reset_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_data_a == '0));

  // R3: index 0 reads zero on both ports.
  p_zero_port_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == '0) |-> (rd_data_a == '0));
  p_zero_port_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_b == '0) |-> (rd_data_b == '0));

  // R2: a write to a nonzero index is read back on the next cycle.
  p_read_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && ($past(wr_addr) != '0) &&
     (rd_addr_b == $past(wr_addr))) |-> (rd_data_b == $past(wr_data)));

  // R4: with no write and an unchanged address, the read word holds.
  p_hold_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en) && (rd_addr_a == $past(rd_addr_a)))
      |-> (rd_data_a == $past(rd_data_a)));

  // R8: the entry-1 tap follows a write to entry 1.
  p_tap_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == ADDR_W'(1))) |=> (obs_e1 == $past(wr_data)));

endmodule

// File: tb/test_regfile_z0.sv
module test_regfile_z0;

  localparam int unsigned DW = 32;
  localparam int unsigned AW = 5;
  localparam int unsigned NVEC = 12;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [AW-1:0] rd_addr_a;
  logic [AW-1:0] rd_addr_b;
  logic [DW-1:0] rd_data_a;
  logic [DW-1:0] rd_data_b;
  logic [DW-1:0] obs_e1, obs_e2, obs_e5, obs_e6;
  logic [DW-1:0] obs_e7, obs_e8, obs_e9, obs_e10;

  int n_checks;
  int n_fails;
  bit done;

  regfile_z0 i_regfile_z0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr_a (rd_addr_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b),
    .obs_e1    (obs_e1),
    .obs_e2    (obs_e2),
    .obs_e5    (obs_e5),
    .obs_e6    (obs_e6),
    .obs_e7    (obs_e7),
    .obs_e8    (obs_e8),
    .obs_e9    (obs_e9),
    .obs_e10   (obs_e10)
  );

  // 125 MHz: 8 ns period.
  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] wa;
    logic [DW-1:0] wd;
    logic [AW-1:0] a1;
    logic [AW-1:0] a2;
    logic [DW-1:0] e1;
    logic [DW-1:0] e2;
    logic [3:0]    req;
  } vec_t;

  // Reads are sampled before the edge that performs the row's write.
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 5'd5,  32'hAAAA0005, 5'd5,  5'd0,  32'h0,        32'h0,        4'd7}, // R7 old word
    '{1'b1, 5'd0,  32'hDEADBEEF, 5'd5,  5'd0,  32'hAAAA0005, 32'h0,        4'd2}, // R2 visible
    '{1'b0, 5'd0,  32'h0,        5'd0,  5'd5,  32'h0,        32'hAAAA0005, 4'd3}, // R3 zero kept
    '{1'b0, 5'd6,  32'h12345678, 5'd6,  5'd6,  32'h0,        32'h0,        4'd4}, // R4 disabled
    '{1'b0, 5'd0,  32'h0,        5'd6,  5'd31, 32'h0,        32'h0,        4'd4}, // R4 no effect
    '{1'b1, 5'd31, 32'hFFFFFFFF, 5'd31, 5'd30, 32'h0,        32'h0,        4'd7}, // R7
    '{1'b1, 5'd30, 32'h80000001, 5'd31, 5'd30, 32'hFFFFFFFF, 32'h0,        4'd2}, // R2
    '{1'b1, 5'd5,  32'h0BADF00D, 5'd30, 5'd5,  32'h80000001, 32'hAAAA0005, 4'd7}, // R7 overwrite
    '{1'b0, 5'd0,  32'h0,        5'd5,  5'd31, 32'h0BADF00D, 32'hFFFFFFFF, 4'd5}, // R5 neighbours
    '{1'b1, 5'd1,  32'h11111111, 5'd1,  5'd2,  32'h0,        32'h0,        4'd5}, // R5
    '{1'b1, 5'd2,  32'h22222222, 5'd1,  5'd29, 32'h11111111, 32'h0,        4'd6}, // R6
    '{1'b0, 5'd0,  32'h0,        5'd2,  5'd1,  32'h22222222, 32'h11111111, 4'd6}  // R6 swapped
  };

  task automatic check(input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic check_obs(input string tag, input logic [DW-1:0] exp [8]);
    check({tag, " e1"},  obs_e1,  exp[0]);
    check({tag, " e2"},  obs_e2,  exp[1]);
    check({tag, " e5"},  obs_e5,  exp[2]);
    check({tag, " e6"},  obs_e6,  exp[3]);
    check({tag, " e7"},  obs_e7,  exp[4]);
    check({tag, " e8"},  obs_e8,  exp[5]);
    check({tag, " e9"},  obs_e9,  exp[6]);
    check({tag, " e10"}, obs_e10, exp[7]);
  endtask

  task automatic drive(input logic we, input logic [AW-1:0] wa,
                       input logic [DW-1:0] wd, input logic [AW-1:0] a1,
                       input logic [AW-1:0] a2);
    @(negedge clk);
    wr_en     = we;
    wr_addr   = wa;
    wr_data   = wd;
    rd_addr_a = a1;
    rd_addr_b = a2;
    #1;
  endtask

  initial begin
    logic [DW-1:0] exp_obs [8];
    n_checks  = 0;
    n_fails   = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    wr_en     = 1'b0;
    wr_addr   = '0;
    wr_data   = '0;
    rd_addr_a = '0;
    rd_addr_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state on ports and taps.
    drive(1'b0, 5'd0, 32'h0, 5'd9, 5'd31);
    check("R1 reset port a", rd_data_a, 32'h0);
    check("R1 reset port b", rd_data_b, 32'h0);
    for (int k = 0; k < 8; k++) exp_obs[k] = 32'h0;
    check_obs("R1 reset tap", exp_obs);

    // Vector table walk.
    for (int v = 0; v < int'(NVEC); v++) begin
      drive(VECS[v].we, VECS[v].wa, VECS[v].wd, VECS[v].a1, VECS[v].a2);
      check($sformatf("R%0d vec %0d port a", VECS[v].req, v), rd_data_a, VECS[v].e1);
      check($sformatf("R%0d vec %0d port b", VECS[v].req, v), rd_data_b, VECS[v].e2);
    end

    // R8: fill remaining tapped entries, then inspect all eight taps.
    for (int k = 6; k <= 10; k++) begin
      drive(1'b1, AW'(k), 32'hC0DE0000 + DW'(k), 5'd0, 5'd0);
    end
    drive(1'b1, 5'd3, 32'h33333333, 5'd0, 5'd0); // untapped, must not show
    drive(1'b0, 5'd0, 32'h0, 5'd3, 5'd10);
    exp_obs[0] = 32'h11111111;
    exp_obs[1] = 32'h22222222;
    exp_obs[2] = 32'h0BADF00D;
    for (int k = 6; k <= 10; k++) exp_obs[k-3] = 32'hC0DE0000 + DW'(k);
    check_obs("R8 taps", exp_obs);
    check("R5 entry 3", rd_data_a, 32'h33333333);
    check("R2 entry 10", rd_data_b, 32'hC0DE000A);

    // R3: repeated writes to index 0 with all-ones data.
    drive(1'b1, 5'd0, 32'hFFFFFFFF, 5'd0, 5'd0);
    drive(1'b1, 5'd0, 32'hFFFFFFFF, 5'd0, 5'd0);
    check("R3 port a", rd_data_a, 32'h0);
    check("R3 port b", rd_data_b, 32'h0);

    // R1: asynchronous reset in mid-run clears everything.
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    rd_addr_a = 5'd31;
    rd_addr_b = 5'd5;
    #1;
    check("R1 async port a", rd_data_a, 32'h0);
    check("R1 async port b", rd_data_b, 32'h0);
    for (int k = 0; k < 8; k++) exp_obs[k] = 32'h0;
    check_obs("R1 async tap", exp_obs);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 5'd0, 32'h0, 5'd30, 5'd1);
    check("R1 after release a", rd_data_a, 32'h0);
    check("R1 after release b", rd_data_b, 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule